// File: doc/BRIEF.md
# Interval Clock-Gating Power Governor

This block caps the power of a memory-heavy chip by withholding clock enables from its memory banks for part of every fixed-length interval. It counts interval positions from 0 to L−1, where L is a software-set length, and keeps an ungated-cycle budget A. The gated count for the interval is G = L − A. Whenever the power sensor presents a sample, the block works out the ratio of the programmed limit to that sample in 8-bit fixed point, using a bit-serial divider. It multiplies the current budget by that ratio and clamps the result. The new budget is held until the next interval boundary.

The G gated cycles can be placed in three ways: as one block at the start of the interval, spread across the interval by error diffusion, or as a block whose start moves by L/N positions from one region to the next, for N clock regions. A control bit applies the memory gating pattern to the processor and cache enables as well. All enables are registered, and the value on the pins at interval position p belongs to position p. Position 0 is the first cycle after reset is released and the first cycle after each boundary. Mode and extend inputs take effect from the next position. L must be at least N and must be held steady while the block runs.

Top module: `gov_clock_governor`

## Requirements
- R1: After reset the budget equals L, and every memory and core enable is 1. While the budget equals L, no enable is ever 0.
- R2: A computed budget equals floor(A × floor(limit × 256 / power) / 256), where A is the budget in force while the result is computed.
- R3: A power sample of 0 makes the ratio saturate to its largest value, so the budget becomes L.
- R4: Every budget is clamped to the range 1 to L. A product of 0 gives 1, and a product above L gives L.
- R5: A new budget takes effect only at the first interval boundary after its computation completes. The interval that is running keeps its earlier gate count for all L positions.
- R6: With mode code 0 or 3 (block), every region is gated at positions 0 to G−1 and enabled at positions G to L−1.
- R7: With mode code 1 (spread), a running value a starts at 0 on each interval and advances as a ← (a + G) mod L. Position p is gated when a_p + G ≥ L. This gives exactly G gated positions per interval, and with G = L/2 every odd position is gated.
- R8: With mode code 2 (rotate), region r is gated at position p when ((p − r·(L/N)) mod L) < G, where N is the number of regions.
- R9: With extend set to 1, the core enables match the memory enables at every position. With extend set to 0, the core enables are all 1.
- R10: A sample strobe that arrives while a computation is in progress is dropped and has no effect on any budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_len_i | input | CNT_W | Interval length L in cycles |
| power_limit_i | input | PWR_W | Programmed power limit |
| sample_valid_i | input | 1 | Power sample strobe |
| sample_power_i | input | PWR_W | Measured power for the interval that has ended |
| gate_mode_i | input | 2 | Placement: 0/3 block, 1 spread, 2 rotate |
| extend_core_i | input | 1 | Apply the gating pattern to the core enables as well |
| mem_clk_en_o | output | 2**RGN_LOG2 | Memory clock enable, one bit per region |
| core_clk_en_o | output | 2**RGN_LOG2 | Processor and cache clock enable, one bit per region |

## Verification
The bench builds the block with 12-bit power and counter widths, a 64-cycle interval and four regions. With these values the 20-step divide finishes well inside one interval, so a sample taken at position 1 shows up exactly one boundary later. A second strobe sent during that divide can be seen to be dropped. The 16-cycle region offset makes the rotated windows wrap across the interval end. A 4000-to-1 limit-to-power ratio pushes the product far above L, which exercises the upper clamp, and a 1-to-4000 ratio drives the quotient to 0, which exercises the lower clamp.

// File: rtl/gov_pkg.sv
package gov_pkg;
  typedef enum logic [1:0] {
    GATE_BLOCK     = 2'd0,
    GATE_SPREAD    = 2'd1,
    GATE_ROTATE    = 2'd2,
    GATE_BLOCK_ALT = 2'd3
  } gate_mode_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_DIV  = 2'd1,
    ENG_MUL  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/gov_ratio_engine.sv
module gov_ratio_engine
  import gov_pkg::*;
#(
  parameter int PWR_W = 16,
  parameter int CNT_W = 16,
  parameter int FRAC  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [PWR_W-1:0] limit_i,
  input  logic [PWR_W-1:0] meas_i,
  input  logic [CNT_W-1:0] avail_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] budget_o
);
  localparam int DW = PWR_W + FRAC;
  localparam int SW = $clog2(DW + 1);
  localparam int PW = CNT_W + DW;
  localparam int XW = DW + PWR_W + 1;

  eng_state_e       state_q;
  logic [PWR_W-1:0] limit_q, meas_q, rem_q, rem_nx;
  logic [DW-1:0]    dvd_q, quo_q;
  logic [SW-1:0]    step_q;
  logic [PWR_W:0]   rem_sh;
  logic             fits;
  logic [PW-1:0]    prod, scaled;
  logic [CNT_W-1:0] clamped;

  always_comb begin
    rem_sh = {rem_q, dvd_q[DW-1]};
    fits   = rem_sh >= {1'b0, meas_q};
    rem_nx = fits ? PWR_W'(rem_sh - {1'b0, meas_q}) : rem_sh[PWR_W-1:0];
    prod   = PW'(avail_i) * PW'(quo_q);
    scaled = prod >> FRAC;
    if (scaled > PW'(len_i))   clamped = len_i;
    else if (scaled == '0)     clamped = CNT_W'(1);
    else                       clamped = scaled[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ENG_IDLE;
      limit_q  <= '0;
      meas_q   <= '0;
      rem_q    <= '0;
      dvd_q    <= '0;
      quo_q    <= '0;
      step_q   <= '0;
      done_o   <= 1'b0;
      budget_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ENG_IDLE: if (start_i) begin
          limit_q <= limit_i;
          meas_q  <= meas_i;
          rem_q   <= '0;
          dvd_q   <= {limit_i, {FRAC{1'b0}}};
          step_q  <= SW'(DW);
          if (meas_i == '0) begin
            quo_q   <= '1;
            state_q <= ENG_MUL;
          end else begin
            quo_q   <= '0;
            state_q <= ENG_DIV;
          end
        end
        ENG_DIV: begin
          rem_q  <= rem_nx;
          dvd_q  <= dvd_q << 1;
          quo_q  <= {quo_q[DW-2:0], fits};
          step_q <= step_q - 1'b1;
          if (step_q == SW'(1)) state_q <= ENG_MUL;
        end
        ENG_MUL: begin
          budget_o <= clamped;
          done_o   <= 1'b1;
          state_q  <= ENG_IDLE;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ENG_IDLE);

  logic [XW-1:0] chk_num, chk_lo, chk_hi;
  always_comb begin
    chk_num = XW'({limit_q, {FRAC{1'b0}}});
    chk_lo  = XW'(quo_q) * XW'(meas_q);
    chk_hi  = (XW'(quo_q) + XW'(1)) * XW'(meas_q);
  end

  // R2: the quotient handed to the multiply stage is the exact floor
  assert_quotient_exact_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ENG_MUL && meas_q != '0) |-> (chk_lo <= chk_num && chk_hi > chk_num));

  // R4: every result leaves inside [1, L]
  assert_budget_bounds_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (budget_o >= CNT_W'(1) && budget_o <= len_i));
endmodule

// File: rtl/gov_pattern.sv
module gov_pattern
  import gov_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RGN_LOG2 = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             mode_i,
  input  logic                   extend_i,
  input  logic [CNT_W-1:0]       len_i,
  input  logic                   start_nx_i,
  input  logic [CNT_W-1:0]       pos_nx_i,
  input  logic [CNT_W-1:0]       gate_cur_i,
  input  logic [CNT_W-1:0]       gate_nx_i,
  output logic [(1<<RGN_LOG2)-1:0] mem_en_o,
  output logic [(1<<RGN_LOG2)-1:0] core_en_o
);
  localparam int RGN = 1 << RGN_LOG2;

  gate_mode_e       mode;
  logic [CNT_W-1:0] acc_q, acc_nx, win;
  logic [CNT_W:0]   acc_sum;
  logic             spread_gate, block_gate;
  logic [RGN-1:0]   rot_gate, en_nx;

  always_comb begin
    mode        = gate_mode_e'(mode_i);
    win         = len_i >> RGN_LOG2;
    acc_sum     = {1'b0, acc_q} + {1'b0, gate_cur_i};
    if (start_nx_i)                  acc_nx = '0;
    else if (acc_sum >= {1'b0, len_i}) acc_nx = CNT_W'(acc_sum - {1'b0, len_i});
    else                             acc_nx = acc_sum[CNT_W-1:0];
    spread_gate = ({1'b0, acc_nx} + {1'b0, gate_nx_i}) >= {1'b0, len_i};
    block_gate  = pos_nx_i < gate_nx_i;
  end

  for (genvar r = 0; r < RGN; r++) begin : g_region
    localparam int unsigned RIDX = r;
    logic [CNT_W-1:0] offs, q;
    logic [CNT_W:0]   shifted;
    always_comb begin
      offs    = CNT_W'(CNT_W'(RIDX) * win);
      shifted = {1'b0, pos_nx_i} + {1'b0, len_i} - {1'b0, offs};
      q       = (shifted >= {1'b0, len_i}) ? CNT_W'(shifted - {1'b0, len_i})
                                           : shifted[CNT_W-1:0];
      rot_gate[r] = q < gate_nx_i;
      case (mode)
        GATE_SPREAD: en_nx[r] = ~spread_gate;
        GATE_ROTATE: en_nx[r] = ~rot_gate[r];
        default:     en_nx[r] = ~block_gate;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      mem_en_o  <= '1;
      core_en_o <= '1;
    end else begin
      acc_q     <= acc_nx;
      mem_en_o  <= en_nx;
      core_en_o <= extend_i ? en_nx : '1;
    end
  end

  // R7: the diffusion remainder never reaches the interval length
  assert_acc_below_len_R7: assert property (@(posedge clk) disable iff (rst)
    acc_q < len_i);

  // R9: core enables stay free when not extended
  assert_core_free_R9: assert property (@(posedge clk) disable iff (rst)
    !extend_i |=> (core_en_o == '1));

  // R9: core enables follow memory enables when extended
  assert_core_follows_R9: assert property (@(posedge clk) disable iff (rst)
    extend_i |=> (core_en_o == mem_en_o));
endmodule

// File: rtl/gov_clock_governor.sv
module gov_clock_governor
  import gov_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PWR_W    = 16,
  parameter int FRAC     = 8,
  parameter int RGN_LOG2 = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CNT_W-1:0]         interval_len_i,
  input  logic [PWR_W-1:0]         power_limit_i,
  input  logic                     sample_valid_i,
  input  logic [PWR_W-1:0]         sample_power_i,
  input  logic [1:0]               gate_mode_i,
  input  logic                     extend_core_i,
  output logic [(1<<RGN_LOG2)-1:0] mem_clk_en_o,
  output logic [(1<<RGN_LOG2)-1:0] core_clk_en_o
);
  logic [CNT_W-1:0] pos_q, pos_nx, avail_q, avail_nx, pend_q;
  logic [CNT_W-1:0] gate_cur, gate_nx, eng_budget;
  logic             pend_v_q, last_pos, eng_busy, eng_done, eng_start;

  always_comb begin
    last_pos  = (pos_q == interval_len_i - 1'b1);
    pos_nx    = last_pos ? '0 : pos_q + 1'b1;
    avail_nx  = (last_pos && pend_v_q) ? pend_q : avail_q;
    gate_cur  = interval_len_i - avail_q;
    gate_nx   = interval_len_i - avail_nx;
    eng_start = sample_valid_i && !eng_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      avail_q  <= interval_len_i;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      pos_q   <= pos_nx;
      avail_q <= avail_nx;
      if (last_pos && pend_v_q) pend_v_q <= 1'b0;
      if (eng_done) begin
        pend_q   <= eng_budget;
        pend_v_q <= 1'b1;
      end
    end
  end

  gov_ratio_engine #(.PWR_W(PWR_W), .CNT_W(CNT_W), .FRAC(FRAC)) ratio_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (eng_start),
    .limit_i  (power_limit_i),
    .meas_i   (sample_power_i),
    .avail_i  (avail_q),
    .len_i    (interval_len_i),
    .busy_o   (eng_busy),
    .done_o   (eng_done),
    .budget_o (eng_budget)
  );

  gov_pattern #(.CNT_W(CNT_W), .RGN_LOG2(RGN_LOG2)) pattern_i (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (gate_mode_i),
    .extend_i   (extend_core_i),
    .len_i      (interval_len_i),
    .start_nx_i (last_pos),
    .pos_nx_i   (pos_nx),
    .gate_cur_i (gate_cur),
    .gate_nx_i  (gate_nx),
    .mem_en_o   (mem_clk_en_o),
    .core_en_o  (core_clk_en_o)
  );

  // R5: the budget only moves on the cycle after an interval's last position
  assert_budget_moves_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(avail_q) |-> $past(last_pos));

  // R1: a full budget never gates a memory region
  assert_full_budget_no_gating_R1: assert property (@(posedge clk) disable iff (rst)
    (avail_q == interval_len_i) |-> (mem_clk_en_o == '1));

  // R4: the budget in force stays in range
  assert_budget_range_R4: assert property (@(posedge clk) disable iff (rst)
    (avail_q >= CNT_W'(1) && avail_q <= interval_len_i));
endmodule

// File: tb/gov_clock_governor_tb_top.sv
`timescale 1ns/1ps
module gov_clock_governor_tb_top;
  localparam int CNT_W    = 12;
  localparam int PWR_W    = 12;
  localparam int FRAC     = 8;
  localparam int RGN_LOG2 = 2;
  localparam int RGN      = 1 << RGN_LOG2;
  localparam int LEN      = 64;
  localparam int WIN      = LEN / RGN;
  localparam int NVEC     = 8;
  // limit, power, expected budget, requirement (2/3/4)
  localparam int VEC [NVEC][4] = '{
    '{100,  200, 32, 2},
    '{150,  100, 48, 2},
    '{90,   120, 36, 2},
    '{100,  300, 11, 2},
    '{1,   4000,  1, 4},
    '{200,  100,  2, 2},
    '{50,     0, 64, 3},
    '{4000,   1, 64, 4}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] interval_len = CNT_W'(LEN);
  logic [PWR_W-1:0] power_limit = '0;
  logic             sample_valid = 1'b0;
  logic [PWR_W-1:0] sample_power = '0;
  logic [1:0]       gate_mode = 2'd0;
  logic             extend_core = 1'b0;
  logic [RGN-1:0]   mem_clk_en, core_clk_en;

  int checks = 0;
  int failures = 0;
  int tb_mode = 0;
  bit tb_ext = 1'b0;

  always #2 clk = ~clk;

  gov_clock_governor #(.CNT_W(CNT_W), .PWR_W(PWR_W), .FRAC(FRAC), .RGN_LOG2(RGN_LOG2)) dut_i (
    .clk            (clk),
    .rst            (rst),
    .interval_len_i (interval_len),
    .power_limit_i  (power_limit),
    .sample_valid_i (sample_valid),
    .sample_power_i (sample_power),
    .gate_mode_i    (gate_mode),
    .extend_core_i  (extend_core),
    .mem_clk_en_o   (mem_clk_en),
    .core_clk_en_o  (core_clk_en)
  );

  function automatic string req_name(input int id);
    case (id)
      2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Walks one interval from position 0; optional strobes at positions 1 and 3.
  task automatic run_interval(input bit inj1, input int lim1, input int pw1,
                              input bit inj2, input int lim2, input int pw2,
                              input int g_exp, input string cnt_req, input string pat_req,
                              input int next_mode, input bit next_ext);
    int gated0 = 0;
    int bad = 0;
    int bad_act = 0;
    int bad_exp = 0;
    int acc = 0;
    for (int p = 0; p < LEN; p++) begin
      bit sp_gate;
      logic [RGN-1:0] exp_mem, exp_core;
      if (inj1 && p == 1) begin
        power_limit = PWR_W'(lim1); sample_power = PWR_W'(pw1); sample_valid = 1'b1;
      end else if (inj2 && p == 3) begin
        power_limit = PWR_W'(lim2); sample_power = PWR_W'(pw2); sample_valid = 1'b1;
      end else begin
        sample_valid = 1'b0;
      end
      sp_gate = (acc + g_exp) >= LEN;
      for (int r = 0; r < RGN; r++) begin
        int q;
        q = (p - r * WIN + LEN) % LEN;
        case (tb_mode)
          1: exp_mem[r] = !sp_gate;
          2: exp_mem[r] = !(q < g_exp);
          default: exp_mem[r] = !(p < g_exp);
        endcase
      end
      acc = (acc + g_exp) % LEN;
      exp_core = tb_ext ? exp_mem : '1;
      if (!mem_clk_en[0]) gated0++;
      if ((mem_clk_en !== exp_mem || core_clk_en !== exp_core) && bad == 0) begin
        bad = 1;
        bad_act = int'({core_clk_en, mem_clk_en});
        bad_exp = int'({exp_core, exp_mem});
      end
      if (p == LEN - 1) begin
        gate_mode = 2'(next_mode);
        extend_core = next_ext;
      end
      @(posedge clk);
      @(negedge clk);
    end
    check(gated0 == g_exp, cnt_req, "gated cycles in interval", gated0, g_exp);
    check(bad == 0, pat_req, "enable pattern {core,mem}", bad_act, bad_exp);
    tb_mode = next_mode;
    tb_ext = next_ext;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R5 watchdog expired: actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int prev_budget;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, all enables high at position 0
    check(mem_clk_en == '1 && core_clk_en == '1, "R1", "enables after reset",
          int'({core_clk_en, mem_clk_en}), (1 << (2 * RGN)) - 1);

    // Table walk: interval i carries sample i and shows result of sample i-1
    prev_budget = LEN;
    for (int i = 0; i < NVEC; i++) begin
      string rq;
      rq = (i == 0) ? "R1" : req_name(VEC[i-1][3]);
      run_interval(1'b1, VEC[i][0], VEC[i][1], 1'b0, 0, 0,
                   LEN - prev_budget, rq, "R5", 0, 1'b0);
      prev_budget = VEC[i][2];
    end

    // R10: second strobe during computation dropped (100/200 kept, not 100/400)
    run_interval(1'b1, 100, 200, 1'b1, 100, 400, LEN - prev_budget,
                 req_name(VEC[NVEC-1][3]), "R5", 0, 1'b0);
    run_interval(1'b0, 0, 0, 1'b0, 0, 0, 32, "R10", "R6", 1, 1'b0);
    // R7: spread placement, G = 32 gives every odd position gated
    run_interval(1'b0, 0, 0, 1'b0, 0, 0, 32, "R7", "R7", 2, 1'b0);
    // R8: rotated windows per region
    run_interval(1'b0, 0, 0, 1'b0, 0, 0, 32, "R8", "R8", 2, 1'b1);
    // R9: core enables follow memory enables
    run_interval(1'b0, 0, 0, 1'b0, 0, 0, 32, "R8", "R9", 3, 1'b0);
    // R6: mode code 3 behaves as block
    run_interval(1'b0, 0, 0, 1'b0, 0, 0, 32, "R6", "R6", 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule